// File: doc/BRIEF.md
# Asynchronous Control Input Qualifier

This block sits between a set of processor control pins and the core logic that acts on them. Any of these pins may change with no fixed relation to the core clock. Every raw pin first passes through a two-flop synchronizer. Pins that are active low are then inverted, so all later logic works on active-high "asserted" values.

The pins fall into two groups. Level pins are filtered: a level output changes only after the synchronized input has held its new value for a minimum number of clocks, so a one-clock glitch never reaches the core. Edge pins are qualified as events. The block issues a single one-cycle event only when the input was negated for the minimum number of clocks and was then held asserted for the same minimum. An assertion that breaks either rule produces no event and sets a sticky violation bit for that pin. The bit is cleared only by reset.

The minimum is two clocks by default. The reset is asynchronous and active low, and its release is synchronized inside the block.

Top module: `ctl_in_qual`

## Requirements
- R1: While reset is asserted, and after its release with all raw inputs at their idle level, every level output, event output and violation bit reads 0.
- R2: Polarity is set per bit by a mask: a mask bit of 1 means the raw pin is asserted when low. The default masks are 4'b1011 for the level group and 4'b1010 for the edge group. Every output is active high.
- R3: A level output takes a new value only after the synchronized input has shown that value for 2 consecutive clocks. A pulse of 1 clock, in either direction, leaves the output unchanged.
- R4: A level output changes on the 4th rising clock edge after the raw input changes (2 synchronizer stages plus 2 qualification clocks).
- R5: An edge input that is negated for at least 2 clocks and then asserted for at least 2 clocks produces one event, one clock wide, on the 4th rising edge after the raw assertion.
- R6: An edge input produces exactly one event per valid assertion, no matter how long it stays asserted.
- R7: An edge assertion shorter than 2 clocks produces no event and sets that input's violation bit.
- R8: An edge assertion preceded by fewer than 2 negated clocks produces no event and sets that input's violation bit. A gap of exactly 2 negated clocks is valid.
- R9: Violation bits are independent per input. Once set, a bit stays set through later valid assertions, which still produce events, and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_raw_i | input | N_LVL | Raw level-sensitive control pins |
| edg_raw_i | input | N_EDG | Raw edge-sensitive control pins |
| lvl_q_o | output | N_LVL | Qualified level outputs, active high |
| edg_evt_o | output | N_EDG | One-cycle event per valid edge assertion |
| edg_viol_o | output | N_EDG | Sticky violation flag per edge input |

## Verification
The bench drives one-clock glitches on both groups. A level filter that reacts too early would let a glitch through or drop a held level. An edge qualifier with the same fault would fire an event instead of flagging a violation. Back-to-back edge pulses are sent with a one-clock gap and with a two-clock gap, which exposes an off-by-one in the negated-time count: the design would either accept the short gap or reject the legal one. A long assertion tests for repeated events. A valid pulse on a pin that already holds a violation tests that the violation stays sticky and that the event still fires. Exact-cycle samples around the fourth edge catch a synchronizer stage that was added or lost.

// File: rtl/ctl_in_qual_pkg.sv
package ctl_in_qual_pkg;
  // Per-input state of the edge qualifier
  typedef enum logic [1:0] {
    EQ_IDLE  = 2'd0,  // negated, counting negated clocks
    EQ_ARMED = 2'd1,  // legal rise seen, counting asserted clocks
    EQ_DONE  = 2'd2   // event issued or assertion rejected, wait for negation
  } eq_state_e;
endpackage

// File: rtl/cq_rst_sync.sv
module cq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/cq_sync_bank.sv
module cq_sync_bank #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cq_level_filter.sv
module cq_level_filter #(
  parameter int unsigned W        = 4,
  parameter int unsigned MIN_CLKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned CW = $clog2(MIN_CLKS + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(MIN_CLKS);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic          last_q;
    logic [CW-1:0] run_q, run_d;
    logic          out_q, out_d;

    // run_d: clocks the current value has been seen, saturating at MIN_CLKS
    always_comb begin
      if (s_i[g] == last_q) run_d = (run_q == RUN_MAX) ? run_q : run_q + CW'(1);
      else                  run_d = CW'(1);
      out_d = (run_d == RUN_MAX) ? s_i[g] : out_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_q <= 1'b0;
        run_q  <= RUN_MAX;
        out_q  <= 1'b0;
      end else begin
        last_q <= s_i[g];
        run_q  <= run_d;
        out_q  <= out_d;
      end
    end

    assign q_o[g] = out_q;
  end
endmodule

// File: rtl/cq_edge_qual.sv
module cq_edge_qual
  import ctl_in_qual_pkg::*;
#(
  parameter int unsigned W        = 4,
  parameter int unsigned MIN_CLKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] viol_o
);
  localparam int unsigned CW = $clog2(MIN_CLKS + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(MIN_CLKS);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic          last_q;
    logic [CW-1:0] run_q, run_d;
    eq_state_e     st_q, st_d;
    logic          evt_q, viol_q;
    logic          rise, fire, bad;

    always_comb begin
      if (s_i[g] == last_q) run_d = (run_q == RUN_MAX) ? run_q : run_q + CW'(1);
      else                  run_d = CW'(1);
      rise = s_i[g] && !last_q;
      fire = 1'b0;
      bad  = 1'b0;
      st_d = st_q;
      unique case (st_q)
        EQ_IDLE: begin
          if (rise) begin
            // run_q still holds the number of negated clocks before the rise
            if (run_q == RUN_MAX) st_d = EQ_ARMED;
            else begin
              bad  = 1'b1;
              st_d = EQ_DONE;
            end
          end
        end
        EQ_ARMED: begin
          if (!s_i[g]) begin
            bad  = 1'b1;
            st_d = EQ_IDLE;
          end else if (run_d == RUN_MAX) begin
            fire = 1'b1;
            st_d = EQ_DONE;
          end
        end
        EQ_DONE: begin
          if (!s_i[g]) st_d = EQ_IDLE;
        end
        default: st_d = EQ_IDLE;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        last_q <= 1'b0;
        run_q  <= '0;
        st_q   <= EQ_IDLE;
        evt_q  <= 1'b0;
        viol_q <= 1'b0;
      end else begin
        last_q <= s_i[g];
        run_q  <= run_d;
        st_q   <= st_d;
        evt_q  <= fire;
        if (bad) viol_q <= 1'b1;
      end
    end

    assign evt_o[g]  = evt_q;
    assign viol_o[g] = viol_q;
  end
endmodule

// File: rtl/ctl_in_qual.sv
module ctl_in_qual #(
  parameter int unsigned N_LVL       = 4,
  parameter int unsigned N_EDG       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_CLKS    = 2,
  parameter logic [N_LVL-1:0] LVL_ACT_LOW = 4'b1011,
  parameter logic [N_EDG-1:0] EDG_ACT_LOW = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_LVL-1:0] lvl_raw_i,
  input  logic [N_EDG-1:0] edg_raw_i,
  output logic [N_LVL-1:0] lvl_q_o,
  output logic [N_EDG-1:0] edg_evt_o,
  output logic [N_EDG-1:0] edg_viol_o
);
  logic             rst_n_core;
  logic [N_LVL-1:0] lvl_sync, lvl_act;
  logic [N_EDG-1:0] edg_sync, edg_act;

  cq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_core)
  );

  // Synchronizers reset to the idle pin level so inversion yields "negated"
  cq_sync_bank #(.W(N_LVL), .STAGES(SYNC_STAGES), .RST_VAL(LVL_ACT_LOW)) u_lvl_sync (
    .clk   (clk),
    .rst_n (rst_n_core),
    .d_i   (lvl_raw_i),
    .q_o   (lvl_sync)
  );

  cq_sync_bank #(.W(N_EDG), .STAGES(SYNC_STAGES), .RST_VAL(EDG_ACT_LOW)) u_edg_sync (
    .clk   (clk),
    .rst_n (rst_n_core),
    .d_i   (edg_raw_i),
    .q_o   (edg_sync)
  );

  assign lvl_act = lvl_sync ^ LVL_ACT_LOW;
  assign edg_act = edg_sync ^ EDG_ACT_LOW;

  cq_level_filter #(.W(N_LVL), .MIN_CLKS(MIN_CLKS)) u_lvl (
    .clk   (clk),
    .rst_n (rst_n_core),
    .s_i   (lvl_act),
    .q_o   (lvl_q_o)
  );

  cq_edge_qual #(.W(N_EDG), .MIN_CLKS(MIN_CLKS)) u_edg (
    .clk    (clk),
    .rst_n  (rst_n_core),
    .s_i    (edg_act),
    .evt_o  (edg_evt_o),
    .viol_o (edg_viol_o)
  );
endmodule

// File: rtl/ctl_in_qual_chk.sv
module ctl_in_qual_chk #(
  parameter int unsigned N_LVL       = 4,
  parameter int unsigned N_EDG       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_CLKS    = 2,
  parameter logic [N_LVL-1:0] LVL_ACT_LOW = 4'b1011,
  parameter logic [N_EDG-1:0] EDG_ACT_LOW = 4'b1010
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_LVL-1:0] lvl_raw_i,
  input logic [N_EDG-1:0] edg_raw_i,
  input logic [N_LVL-1:0] lvl_q_o,
  input logic [N_EDG-1:0] edg_evt_o,
  input logic [N_EDG-1:0] edg_viol_o
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (lvl_q_o == '0 && edg_evt_o == '0 && edg_viol_o == '0)); // R1

  // Fixed-depth timing checks apply to the default pipeline only
  if (SYNC_STAGES == 2 && MIN_CLKS == 2) begin : g_timing
    for (genvar i = 0; i < N_LVL; i++) begin : g_lvl
      AST_LVL_HELD_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(lvl_q_o[i]) |->
          ($past(lvl_raw_i[i], 3) == $past(lvl_raw_i[i], 4)) &&
          (lvl_q_o[i] == ($past(lvl_raw_i[i], 3) ^ LVL_ACT_LOW[i]))); // R3
    end
    for (genvar i = 0; i < N_EDG; i++) begin : g_edg
      AST_EVT_LEGAL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        edg_evt_o[i] |->
          (($past(edg_raw_i[i], 3) ^ EDG_ACT_LOW[i]) == 1'b1) &&
          (($past(edg_raw_i[i], 4) ^ EDG_ACT_LOW[i]) == 1'b1) &&
          (($past(edg_raw_i[i], 5) ^ EDG_ACT_LOW[i]) == 1'b0) &&
          (($past(edg_raw_i[i], 6) ^ EDG_ACT_LOW[i]) == 1'b0)); // R5
    end
  end

  for (genvar i = 0; i < N_EDG; i++) begin : g_each
    AST_EVT_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      edg_evt_o[i] |=> !edg_evt_o[i]); // R6
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      edg_viol_o[i] |=> edg_viol_o[i]); // R9
    AST_VIOL_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(edg_viol_o[i]) |-> !edg_evt_o[i]); // R7
  end
endmodule

bind ctl_in_qual ctl_in_qual_chk #(
  .N_LVL(N_LVL), .N_EDG(N_EDG), .SYNC_STAGES(SYNC_STAGES), .MIN_CLKS(MIN_CLKS),
  .LVL_ACT_LOW(LVL_ACT_LOW), .EDG_ACT_LOW(EDG_ACT_LOW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lvl_raw_i  (lvl_raw_i),
  .edg_raw_i  (edg_raw_i),
  .lvl_q_o    (lvl_q_o),
  .edg_evt_o  (edg_evt_o),
  .edg_viol_o (edg_viol_o)
);

// File: tb/ctl_in_qual_bench.sv
`timescale 1ns/1ps
module ctl_in_qual_bench;
  localparam logic [3:0] LM = 4'b1011;
  localparam logic [3:0] EM = 4'b1010;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] lvl_raw, edg_raw;
  logic [3:0] lvl_q, evt, viol;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  int ecnt [4];

  always #2.5 clk = ~clk;

  ctl_in_qual u_ctl_in_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_raw_i  (lvl_raw),
    .edg_raw_i  (edg_raw),
    .lvl_q_o    (lvl_q),
    .edg_evt_o  (evt),
    .edg_viol_o (viol)
  );

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) if (rst_n === 1'b1 && evt[i] === 1'b1) ecnt[i]++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_lvl(input int i, input logic a);
    lvl_raw[i] = LM[i] ^ a;
  endtask

  task automatic set_edg(input int i, input logic a);
    edg_raw[i] = EM[i] ^ a;
  endtask

  task automatic pulse_edg(input int i, input int n);
    set_edg(i, 1'b1);
    tick(n);
    set_edg(i, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    lvl_raw = LM;
    edg_raw = EM;
    tick(3);
    chk("R1", "levels in reset", 32'(lvl_q), 0);
    chk("R1", "events/viol in reset", 32'({evt, viol}), 0);
    rst_n = 1'b1;
    tick(8);
    chk("R2", "idle active-low pins read negated", 32'(lvl_q), 0);
    chk("R1", "events/viol after release", 32'({evt, viol}), 0);
  endtask

  task automatic t_lvl_valid();
    set_lvl(1, 1'b1);
    tick(2);
    set_lvl(1, 1'b0);
    tick(1);
    chk("R4", "lvl1 before 4th edge", 32'(lvl_q[1]), 0);
    tick(1);
    chk("R4", "lvl1 at 4th edge", 32'(lvl_q[1]), 1);
    tick(1);
    chk("R3", "lvl1 held", 32'(lvl_q[1]), 1);
    tick(1);
    chk("R3", "lvl1 released", 32'(lvl_q[1]), 0);
    tick(4);
  endtask

  task automatic t_lvl_glitch();
    logic seen = 1'b0;
    set_lvl(2, 1'b1);
    tick(1);
    set_lvl(2, 1'b0);
    for (int k = 0; k < 8; k++) begin
      tick(1);
      if (lvl_q[2]) seen = 1'b1;
    end
    chk("R3", "1-clock level glitch ignored", 32'(seen), 0);
  endtask

  task automatic t_lvl_all();
    logic drop = 1'b0;
    for (int i = 0; i < 4; i++) set_lvl(i, 1'b1);
    tick(6);
    chk("R2", "all level bits asserted", 32'(lvl_q), 32'hF);
    set_lvl(0, 1'b0);
    tick(1);
    set_lvl(0, 1'b1);
    for (int k = 0; k < 8; k++) begin
      tick(1);
      if (lvl_q !== 4'hF) drop = 1'b1;
    end
    chk("R3", "1-clock negation glitch ignored", 32'(drop), 0);
    for (int i = 0; i < 4; i++) set_lvl(i, 1'b0);
    tick(6);
    chk("R3", "all level bits released", 32'(lvl_q), 0);
  endtask

  task automatic t_edg_valid();
    int c0 = ecnt[0];
    set_edg(0, 1'b1);
    tick(2);
    set_edg(0, 1'b0);
    tick(1);
    chk("R5", "edge0 no event before 4th edge", 32'(evt), 0);
    tick(1);
    chk("R5", "edge0 event at 4th edge", 32'(evt), 32'h1);
    tick(1);
    chk("R5", "edge0 event one cycle", 32'(evt), 0);
    tick(6);
    chk("R5", "edge0 single event", 32'(ecnt[0] - c0), 1);
    chk("R5", "no violation on legal pulse", 32'(viol), 0);
  endtask

  task automatic t_edg_long();
    int c1 = ecnt[1];
    pulse_edg(1, 20);
    tick(8);
    chk("R6", "long hold yields one event", 32'(ecnt[1] - c1), 1);
    chk("R6", "long hold no violation", 32'(viol), 0);
  endtask

  task automatic t_edg_glitch();
    int c2 = ecnt[2];
    pulse_edg(2, 1);
    tick(8);
    chk("R7", "short assertion no event", 32'(ecnt[2] - c2), 0);
    chk("R7", "short assertion flags only bit2", 32'(viol), 32'h4);
  endtask

  task automatic t_edg_gap_short();
    int c3 = ecnt[3];
    pulse_edg(3, 3);
    tick(1);
    pulse_edg(3, 3);
    tick(8);
    chk("R8", "1-clock gap: only first event", 32'(ecnt[3] - c3), 1);
    chk("R8", "1-clock gap flags bit3", 32'(viol), 32'hC);
  endtask

  task automatic t_edg_gap_ok();
    int c0 = ecnt[0];
    pulse_edg(0, 3);
    tick(2);
    pulse_edg(0, 3);
    tick(8);
    chk("R8", "2-clock gap: two events", 32'(ecnt[0] - c0), 2);
    chk("R8", "2-clock gap no new violation", 32'(viol), 32'hC);
  endtask

  task automatic t_sticky();
    int c2 = ecnt[2];
    pulse_edg(2, 3);
    tick(8);
    chk("R9", "flagged input still fires", 32'(ecnt[2] - c2), 1);
    chk("R9", "violation stays set", 32'(viol), 32'hC);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(6);
    chk("R9", "reset clears violations", 32'(viol), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) ecnt[i] = 0;
    t_reset();
    t_lvl_valid();
    t_lvl_glitch();
    t_lvl_all();
    t_edg_valid();
    t_edg_long();
    t_edg_glitch();
    t_edg_gap_short();
    t_edg_gap_ok();
    t_sticky();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule